// File: doc/BRIEF.md
# Receive FIFO error tracker

This block is the receive-side holding queue of a serial port. Each received byte goes in together with three error flags: parity error, framing error and break. The host pops bytes from the head and sees the head byte with its own flags. The block also keeps a running count of how many stored entries carry at least one error flag. A summary bit is derived from that count, so the host can tell from one bit whether any errored character is still waiting in the queue, even when the head entry is clean.

A push into a full queue is dropped and reported as an overrun pulse. An overrun detected elsewhere in the receiver can also be reported through a separate event input. The line-status interrupt request combines the summary bit and the overrun pulse, gated by an enable bit.

Top module: `rxq_err_tracker`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `full_o`=0), and `err_sum_o`, `err_count_o`, `overrun_o` and `lsi_irq_o` are all 0.
- R2: Entries leave in the order they were accepted, each with its byte and all three flags intact. While the queue is empty the head outputs read 0.
- R3: `full_o` is 1 exactly when DEPTH entries are stored, and `empty_o` is 1 exactly when none are stored. A pop while empty is ignored.
- R4: A push while full with no pop in the same cycle is discarded, and `overrun_o` is 1 for the following cycle. A push while full together with a pop is accepted.
- R5: `err_count_o` equals the number of stored entries whose parity, framing or break flag is set. It is updated in the cycle after the push or pop.
- R6: `err_sum_o` is 1 exactly when at least one stored entry carries an error flag. It returns to 0 the cycle after the last errored entry is popped.
- R7: An accepted errored push in the same cycle as a pop of an errored head leaves `err_count_o` unchanged.
- R8: A pulse on `overrun_ev_i` makes `overrun_o` 1 for the following cycle.
- R9: `lsi_irq_o` = `lsi_en_i` AND (`err_sum_o` OR `overrun_o`). It follows the enable input within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request from the receiver |
| push_data_i | input | 8 | Received byte |
| push_perr_i | input | 1 | Parity error flag of the byte |
| push_ferr_i | input | 1 | Framing error flag of the byte |
| push_brk_i | input | 1 | Break flag of the byte |
| pop_i | input | 1 | Pop request from the host |
| overrun_ev_i | input | 1 | Overrun detected outside the queue |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| head_data_o | output | 8 | Byte at the head (0 when empty) |
| head_perr_o | output | 1 | Parity flag of the head entry |
| head_ferr_o | output | 1 | Framing flag of the head entry |
| head_brk_o | output | 1 | Break flag of the head entry |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| err_count_o | output | $clog2(DEPTH+1) | Number of stored errored entries |
| err_sum_o | output | 1 | Any stored entry has an error |
| overrun_o | output | 1 | One-cycle overrun indication |
| lsi_irq_o | output | 1 | Line-status interrupt request |

## Verification
The hardest case to reach is a full queue whose only errored entries sit deep behind clean ones, with an errored push and an errored pop landing in the same cycle at the full boundary. Random traffic seldom lines these up. Directed phases therefore fill the queue with errors only at chosen slots, and then push and pop together while full. The random phase biases push probability upward and error probability to about one in three, so that the queue swings between empty and full while the summary bit toggles many times.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              brk;
    logic              ferr;
    logic              perr;
  } rxq_entry_t;

  function automatic logic entry_bad(input rxq_entry_t e);
    return e.perr | e.ferr | e.brk;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] lvl;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      lvl <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   lvl <= lvl + 1'b1;
        2'b01:   lvl <= lvl - 1'b1;
        default: lvl <= lvl;
      endcase
    end
  end

  assign full    = (lvl == LW'(DEPTH));
  assign empty   = (lvl == '0);
  assign rd_data = empty ? '0 : mem[rp];
endmodule

// File: rtl/rxq_err_count.sv
module rxq_err_count #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          nonzero
);
  function automatic logic [CW-1:0] step(input logic [CW-1:0] c,
                                          input logic up, input logic dn);
    if (up && !dn) return c + 1'b1;
    if (dn && !up) return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= step(cnt, inc, dec);
  end

  assign nonzero = (cnt != '0);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic ext_ovr,
  input  logic err_any,
  input  logic en,
  output logic ovr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) ovr <= 1'b0;
    else        ovr <= drop | ext_ovr;
  end

  assign irq = en & (err_any | ovr);
endmodule

// File: rtl/rxq_err_tracker.sv
module rxq_err_tracker
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_perr_i,
  input  logic              push_ferr_i,
  input  logic              push_brk_i,
  input  logic              pop_i,
  input  logic              overrun_ev_i,
  input  logic              lsi_en_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              head_perr_o,
  output logic              head_ferr_o,
  output logic              head_brk_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  err_count_o,
  output logic              err_sum_o,
  output logic              overrun_o,
  output logic              lsi_irq_o
);
  localparam int EW = $bits(rxq_entry_t);

  rxq_entry_t in_e, head_e;
  logic push_acc, pop_acc, push_bad, pop_bad, drop_ev;

  assign in_e     = '{data: push_data_i, brk: push_brk_i,
                      ferr: push_ferr_i, perr: push_perr_i};
  assign pop_acc  = pop_i & ~empty_o;
  assign push_acc = push_i & (~full_o | pop_acc);
  assign drop_ev  = push_i & ~push_acc;
  assign push_bad = push_acc & entry_bad(in_e);
  assign pop_bad  = pop_acc & entry_bad(head_e);

  rxq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(push_acc), .wr_data(in_e),
    .rd_en(pop_acc), .rd_data(head_e),
    .full(full_o), .empty(empty_o)
  );

  rxq_err_count #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .inc(push_bad), .dec(pop_bad),
    .cnt(err_count_o), .nonzero(err_sum_o)
  );

  rxq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .drop(drop_ev), .ext_ovr(overrun_ev_i),
    .err_any(err_sum_o), .en(lsi_en_i),
    .ovr(overrun_o), .irq(lsi_irq_o)
  );

  assign head_data_o = head_e.data;
  assign head_perr_o = head_e.perr;
  assign head_ferr_o = head_e.ferr;
  assign head_brk_o  = head_e.brk;
endmodule

// File: rtl/rxq_err_tracker_chk.sv
module rxq_err_tracker_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          overrun_ev_i,
  input logic          lsi_en_i,
  input logic          empty_o,
  input logic          full_o,
  input logic [CW-1:0] err_count_o,
  input logic          err_sum_o,
  input logic          overrun_o,
  input logic          lsi_irq_o,
  input logic          push_acc,
  input logic          pop_acc,
  input logic          push_bad,
  input logic          pop_bad
);
  a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  a_r4_drop_flags_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i) |=> overrun_o);

  a_r5_bad_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (push_bad && !pop_bad) |=> (err_count_o == $past(err_count_o) + 1'b1));

  a_r6_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (!err_sum_o && err_count_o == '0));

  a_r7_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_bad && pop_bad) |=> $stable(err_count_o));

  a_r8_ext_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev_i |=> overrun_o);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !lsi_en_i |-> !lsi_irq_o);

  a_r2_pop_only_when_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop_acc |-> !empty_o);
endmodule

bind rxq_err_tracker rxq_err_tracker_chk #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .overrun_ev_i(overrun_ev_i), .lsi_en_i(lsi_en_i),
  .empty_o(empty_o), .full_o(full_o), .err_count_o(err_count_o),
  .err_sum_o(err_sum_o), .overrun_o(overrun_o), .lsi_irq_o(lsi_irq_o),
  .push_acc(push_acc), .pop_acc(pop_acc),
  .push_bad(push_bad), .pop_bad(pop_bad)
);

// File: tb/rxq_err_tracker_tb_top.sv
module rxq_err_tracker_tb_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0, ovr_ev = 1'b0, en = 1'b0;
  logic perr = 1'b0, ferr = 1'b0, brk = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] h_data;
  logic h_perr, h_ferr, h_brk, emp, ful, esum, ovr, irq;
  logic [CW-1:0] ecnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model entry: {data[7:0], brk, ferr, perr}
  logic [10:0] mq[$];
  bit m_ovr = 0;

  always #4 clk = ~clk;

  rxq_err_tracker #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .push_data_i(din), .push_perr_i(perr),
    .push_ferr_i(ferr), .push_brk_i(brk), .pop_i(pop),
    .overrun_ev_i(ovr_ev), .lsi_en_i(en),
    .head_data_o(h_data), .head_perr_o(h_perr), .head_ferr_o(h_ferr),
    .head_brk_o(h_brk), .empty_o(emp), .full_o(ful),
    .err_count_o(ecnt), .err_sum_o(esum), .overrun_o(ovr),
    .lsi_irq_o(irq)
  );

  function automatic int bad_entries();
    int n = 0;
    foreach (mq[i]) if (mq[i][2:0] != 3'b000) n++;
    return n;
  endfunction

  task automatic check(input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_all();
    int nb = bad_entries();
    logic [10:0] hd = (mq.size() > 0) ? mq[0] : 11'd0;
    check("R2", "head data", int'(h_data), int'(hd[10:3]));
    check("R2", "head flags", int'({h_brk, h_ferr, h_perr}), int'(hd[2:0]));
    check("R3", "empty", int'(emp), int'(mq.size() == 0));
    check("R3", "full", int'(ful), int'(mq.size() == DEPTH));
    check("R5", "err count", int'(ecnt), nb);
    check("R6", "err sum", int'(esum), int'(nb > 0));
    check("R4_R8", "overrun", int'(ovr), int'(m_ovr));
    check("R9", "irq", int'(irq), int'(en && (nb > 0 || m_ovr)));
  endtask

  task automatic step(input bit ps, input bit pp, input bit ev,
                      input logic [7:0] d, input logic [2:0] fl);
    bit pop_ok, push_ok;
    push = ps; pop = pp; ovr_ev = ev; din = d;
    {brk, ferr, perr} = fl;
    @(posedge clk);
    pop_ok  = pp && mq.size() > 0;
    push_ok = ps && (mq.size() < DEPTH || pop_ok);
    if (pop_ok) void'(mq.pop_front());
    if (push_ok) mq.push_back({d, fl});
    m_ovr = (ps && !push_ok) || ev;
    #2;
    check_all();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "empty", int'(emp), 1);
    check("R1", "full", int'(ful), 0);
    check("R1", "sum", int'(esum), 0);
    check("R1", "count", int'(ecnt), 0);
    check("R1", "overrun", int'(ovr), 0);
    check("R1", "irq", int'(irq), 0);
    rst_n = 1'b1;

    // R3: pop while empty ignored
    step(0, 1, 0, 8'h00, 3'b000);
    // R2/R6: clean entries then one errored entry deep in the queue
    for (int i = 0; i < DEPTH - 1; i++)
      step(1, 0, 0, 8'(i + 8'h10), (i == 9) ? 3'b010 : 3'b000);
    // fill last slot with break entry -> full
    step(1, 0, 0, 8'hA5, 3'b100);
    // R4: push while full dropped, overrun pulse
    step(1, 0, 0, 8'hEE, 3'b001);
    step(0, 0, 0, 8'h00, 3'b000);
    // R4: push with pop while full accepted
    step(1, 1, 0, 8'h5A, 3'b001);
    // R9: enable masks irq
    en = 1'b0;
    step(0, 0, 0, 8'h00, 3'b000);
    en = 1'b1;
    // drain: R6 sum clears after last errored entry popped
    while (mq.size() > 0) step(0, 1, 0, 8'h00, 3'b000);
    // R8 external overrun, enabled and masked
    step(0, 0, 1, 8'h00, 3'b000);
    en = 1'b0;
    step(0, 0, 1, 8'h00, 3'b000);
    en = 1'b1;
    // R7: errored push and errored pop together
    step(1, 0, 0, 8'h33, 3'b001);
    step(1, 1, 0, 8'h44, 3'b010);
    step(1, 1, 0, 8'h55, 3'b100);
    step(0, 1, 0, 8'h00, 3'b000);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit ps, pp, ev;
      logic [2:0] fl;
      ps = ($urandom % 100) < ((n / 500) % 2 ? 70 : 40);
      pp = ($urandom % 100) < ((n / 500) % 2 ? 35 : 60);
      ev = ($urandom % 50) == 0;
      fl = (($urandom % 3) == 0) ? 3'($urandom % 7 + 1) : 3'b000;
      en = ($urandom % 8) != 0;
      step(ps, pp, ev, 8'($urandom), fl);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule